// File: doc/BRIEF.md
# Single-Channel Memory Copy Engine with Start Latency

This block is one copy channel for a processor subsystem. Software loads a source address, a destination address and a control word through a simple register write port. Setting the run bit in the control word schedules a copy of a given number of 16-bit or 32-bit units. The copy does not begin on that write. A fixed start latency of two clock cycles runs first. When it ends, the channel samples its address registers and takes the memory bus. It then holds the processor off the bus until the last unit has been stored.

Each unit is a read cycle followed by a write cycle on a master port with a request/ready handshake, so memory may insert wait states. Addresses start aligned to the unit size and advance by the unit size after each unit. At the end the channel clears its run bit and its count field. It can also raise a one-cycle interrupt, which lets software start the next copy without first writing a disable. A control write with the run bit clear aborts a pending or running copy.

The control word is laid out as follows. The unit count is in bits 15:0, and a count of 0 means 65536 units. Bit 26 selects the unit width, bit 30 enables the interrupt and bit 31 is the run bit. Register select 0 is the source, 1 is the destination and 2 is the control word.

Top module: `dma_copy_channel`

## Requirements
- R1: After reset, `mem_req`, `cpu_halt` and `irq` are low and `ctrl_view` reads zero.
- R2: Suppose a control write with bit 31 set is accepted at clock edge k. Then `mem_req` stays low after edges k and k+1 and is high after edge k+2, with the first read addressed at the sampled source.
- R3: The source and destination registers are sampled at edge k+2. A source write accepted at edge k+1 is used by that copy, and a source write accepted at edge k+2 is not.
- R4: Each unit is one read (`mem_we` low) followed by one write (`mem_we` high). A transfer completes at an edge where `mem_req` and `mem_ready` are both high. While `mem_ready` is low, the request, its address and its direction hold steady.
- R5: When control bit 26 is 1, units are 32 bits wide: `mem_size` is 1, addresses have bits 1:0 cleared and advance by 4. When bit 26 is 0, units are 16 bits wide: `mem_size` is 0, address bit 0 is cleared, addresses advance by 2, and `mem_wdata` bits 31:16 are zero.
- R6: The unit count is control bits 15:0. A value of 0 copies 65536 units.
- R7: `cpu_halt` is high whenever `mem_req` is high. It drops in the cycle after the edge that accepts the final write.
- R8: After a copy completes, `ctrl_view` reads bit 31 and bits 15:0 as zero. Bits 26 and 30 keep their written values.
- R9: With control bit 30 set, `irq` is high for exactly one cycle, in the cycle after the final write is accepted. With bit 30 clear, `irq` stays low.
- R10: A control write with bit 31 clear, accepted while a copy is pending or running, stops the copy. From the next cycle there is no further request and `cpu_halt` is low.
- R11: Once a copy has completed, a new control write with bit 31 set starts the next copy with the same latency, and no disable write is needed in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 source, 1 destination, 2 control |
| reg_wdata | input | 32 | Register write data |
| ctrl_view | output | 32 | Control word read view, showing the live count while a copy runs |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 for a write cycle, 0 for a read cycle |
| mem_size | output | 1 | 1 for 32-bit units, 0 for 16-bit units |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid together with `mem_ready` |
| mem_ready | input | 1 | Memory accepts the current request at this edge |
| cpu_halt | output | 1 | Holds the processor off the bus |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The first read request is due two edges after the edge that accepts the enabling control write. The bench drives each register write into one specific edge and samples one nanosecond after each following edge, so it can name the exact edge at which the request must appear and which address writes land inside the latency window. Write data and addresses are checked at the moment each write is accepted, as a scoreboard pops the next expected unit. The interrupt and the drop of `cpu_halt` are due in the cycle after the final accepted write. An abort must take effect in the cycle after its own edge, and the bench checks that no further writes follow.

// File: rtl/dma_ch_pkg.sv
package dma_ch_pkg;

  parameter int ADDR_W = 32;
  parameter int DATA_W = 32;
  parameter int CNT_W  = 16;
  localparam int REM_W = CNT_W + 1;

  // control word bit positions
  localparam int RUN_BIT  = 31;
  localparam int IRQE_BIT = 30;
  localparam int WIDE_BIT = 26;

  // register selects
  localparam logic [1:0] SEL_SRC = 2'd0;
  localparam logic [1:0] SEL_DST = 2'd1;
  localparam logic [1:0] SEL_CTL = 2'd2;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_READ  = 2'd1,
    XS_WRITE = 2'd2
  } xfer_state_e;

  // byte step between units
  function automatic logic [ADDR_W-1:0] unit_step(input logic wide);
    return wide ? ADDR_W'(4) : ADDR_W'(2);
  endfunction

  // clear the low address bits that fall inside one unit
  function automatic logic [ADDR_W-1:0] unit_align(input logic [ADDR_W-1:0] a,
                                                   input logic wide);
    logic [ADDR_W-1:0] m;
    m = wide ? ~ADDR_W'(3) : ~ADDR_W'(1);
    return a & m;
  endfunction

  // a programmed count of zero stands for the full range
  function automatic logic [REM_W-1:0] units_to_move(input logic [CNT_W-1:0] c);
    return (c == '0) ? (REM_W'(1) << CNT_W) : {1'b0, c};
  endfunction

  // narrow units travel on the low lanes with the upper lanes zeroed
  function automatic logic [DATA_W-1:0] unit_lanes(input logic [DATA_W-1:0] d,
                                                   input logic wide);
    return wide ? d : {{(DATA_W-16){1'b0}}, d[15:0]};
  endfunction

endpackage

// File: rtl/dma_ch_regs.sv
module dma_ch_regs
  import dma_ch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  input  logic              done_evt,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic [31:0]       ctl_q,
  output logic              start_evt,
  output logic              stop_evt
);

  logic ctl_wr;
  assign ctl_wr    = reg_we && (reg_sel == SEL_CTL);
  assign start_evt = ctl_wr &&  reg_wdata[RUN_BIT];
  assign stop_evt  = ctl_wr && !reg_wdata[RUN_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      ctl_q <= '0;
    end else begin
      if (reg_we && reg_sel == SEL_SRC) src_q <= reg_wdata[ADDR_W-1:0];
      if (reg_we && reg_sel == SEL_DST) dst_q <= reg_wdata[ADDR_W-1:0];
      if (ctl_wr) begin
        ctl_q <= reg_wdata;
      end else if (done_evt) begin
        ctl_q[RUN_BIT]    <= 1'b0;
        ctl_q[CNT_W-1:0]  <= '0;
      end
    end
  end

endmodule

// File: rtl/dma_ch_delay.sv
module dma_ch_delay #(
  parameter int START_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_evt,
  input  logic stop_evt,
  output logic launch,
  output logic pending
);

  localparam int LW = $clog2(START_LAT + 1);
  localparam logic [LW-1:0] LOAD = LW'(START_LAT);

  logic [LW-1:0] wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  wait_q <= '0;
    else if (start_evt)          wait_q <= LOAD;
    else if (stop_evt)           wait_q <= '0;
    else if (wait_q != '0)       wait_q <= wait_q - 1'b1;
  end

  assign pending = (wait_q != '0);
  // the last waiting cycle: the next edge samples the address registers
  assign launch  = (wait_q == LW'(1)) && !start_evt && !stop_evt;

endmodule

// File: rtl/dma_ch_engine.sv
module dma_ch_engine
  import dma_ch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              abort,
  input  logic [ADDR_W-1:0] src_in,
  input  logic [ADDR_W-1:0] dst_in,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic              wide_in,
  input  logic              irqe_in,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_size,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy,
  output logic [REM_W-1:0]  remain,
  output logic              done_evt,
  output logic              irq
);

  xfer_state_e       state_q;
  logic [ADDR_W-1:0] rd_ptr_q, wr_ptr_q;
  logic [DATA_W-1:0] hold_q;
  logic [REM_W-1:0]  rem_q;
  logic              wide_q;
  logic              irq_q;

  assign done_evt = (state_q == XS_WRITE) && mem_ready && (rem_q == REM_W'(1)) && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= XS_IDLE;
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      hold_q   <= '0;
      rem_q    <= '0;
      wide_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= done_evt && irqe_in;
      if (abort) begin
        state_q <= XS_IDLE;
      end else begin
        case (state_q)
          XS_IDLE: if (launch) begin
            rd_ptr_q <= unit_align(src_in, wide_in);
            wr_ptr_q <= unit_align(dst_in, wide_in);
            rem_q    <= units_to_move(cnt_in);
            wide_q   <= wide_in;
            state_q  <= XS_READ;
          end
          XS_READ: if (mem_ready) begin
            hold_q  <= mem_rdata;
            state_q <= XS_WRITE;
          end
          XS_WRITE: if (mem_ready) begin
            rd_ptr_q <= rd_ptr_q + unit_step(wide_q);
            wr_ptr_q <= wr_ptr_q + unit_step(wide_q);
            rem_q    <= rem_q - 1'b1;
            state_q  <= (rem_q == REM_W'(1)) ? XS_IDLE : XS_READ;
          end
          default: state_q <= XS_IDLE;
        endcase
      end
    end
  end

  assign busy      = (state_q != XS_IDLE);
  assign mem_req   = busy;
  assign mem_we    = (state_q == XS_WRITE);
  assign mem_size  = wide_q;
  assign mem_addr  = (state_q == XS_WRITE) ? wr_ptr_q : rd_ptr_q;
  assign mem_wdata = unit_lanes(hold_q, wide_q);
  assign remain    = rem_q;
  assign irq       = irq_q;

endmodule

// File: rtl/dma_copy_channel.sv
module dma_copy_channel
  import dma_ch_pkg::*;
#(
  parameter int START_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       ctrl_view,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_size,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              cpu_halt,
  output logic              irq
);

  // named internal events, also used by the bound checker
  logic              start_evt, stop_evt, launch, pending, done_evt, busy;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [31:0]       ctl_q;
  logic [REM_W-1:0]  remain;

  dma_ch_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .done_evt  (done_evt),
    .src_q     (src_q),
    .dst_q     (dst_q),
    .ctl_q     (ctl_q),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  dma_ch_delay #(.START_LAT(START_LAT)) u_delay (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .launch    (launch),
    .pending   (pending)
  );

  dma_ch_engine u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .abort     (start_evt || stop_evt),
    .src_in    (src_q),
    .dst_in    (dst_q),
    .cnt_in    (ctl_q[CNT_W-1:0]),
    .wide_in   (ctl_q[WIDE_BIT]),
    .irqe_in   (ctl_q[IRQE_BIT]),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_size  (mem_size),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .busy      (busy),
    .remain    (remain),
    .done_evt  (done_evt),
    .irq       (irq)
  );

  assign cpu_halt  = busy;
  assign ctrl_view = busy ? {ctl_q[31:CNT_W], remain[CNT_W-1:0]} : ctl_q;

endmodule

// File: rtl/dma_ch_checker.sv
module dma_ch_checker
  import dma_ch_pkg::*;
#(
  parameter int START_LAT = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [1:0]        reg_sel,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       ctrl_view,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_size,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ready,
  input logic              cpu_halt,
  input logic              irq,
  input logic              start_evt,
  input logic              launch,
  input logic              done_evt
);

  logic        ctl_wr, cancel_wr;
  logic [15:0] since_start;

  assign ctl_wr    = reg_we && (reg_sel == SEL_CTL);
  assign cancel_wr = ctl_wr && !reg_wdata[RUN_BIT];

  // cycles elapsed since the last enabling write, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    since_start <= 16'hFFFF;
    else if (start_evt)            since_start <= '0;
    else if (since_start != 16'hFFFF) since_start <= since_start + 1'b1;
  end

  AST_NO_EARLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !mem_req);                                                  // R2
  AST_LAUNCH_AT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (since_start == 16'(START_LAT - 1)));                          // R2
  AST_HALT_COVERS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> cpu_halt);                                                    // R7
  AST_DONE_DROPS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !cpu_halt);                                                  // R7
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready && !ctl_wr) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R4
  AST_ALIGN_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_size) |-> (mem_addr[1:0] == 2'b00));                      // R5
  AST_ALIGN_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_addr[0]);                                                // R5
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);                                                            // R9
  AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!ctrl_view[RUN_BIT] && ctrl_view[CNT_W-1:0] == '0));             // R8
  AST_CANCEL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_wr |=> (!mem_req && !cpu_halt));                                   // R10

endmodule

bind dma_copy_channel dma_ch_checker #(.START_LAT(START_LAT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .ctrl_view (ctrl_view),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_size  (mem_size),
  .mem_addr  (mem_addr),
  .mem_ready (mem_ready),
  .cpu_halt  (cpu_halt),
  .irq       (irq),
  .start_evt (start_evt),
  .launch    (launch),
  .done_evt  (done_evt)
);

// File: tb/sim_dma_copy_channel.sv
`timescale 1ns/1ps
module sim_dma_copy_channel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] ctrl_view;
  logic        mem_req, mem_we, mem_size, cpu_halt, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_ready = 1'b1;

  always #2 clk = ~clk;   // 250 MHz

  dma_copy_channel u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ctrl_view(ctrl_view), .mem_req(mem_req),
    .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .cpu_halt(cpu_halt), .irq(irq)
  );

  // memory content model: data is a scrambled copy of the byte address
  function automatic logic [31:0] mem_pattern(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h0F0F1234;
  endfunction
  assign mem_rdata = mem_pattern(mem_addr);

  typedef struct { logic [31:0] addr; logic [31:0] data; logic wide; } wr_item_t;
  wr_item_t sb[$];

  int n_cmp = 0, n_bad = 0;
  int wr_seen = 0, irq_seen = 0, req_seen = 0;
  bit ready_mode = 0;
  logic [7:0] lfsr = 8'h5B;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // wait states
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready <= ready_mode ? (lfsr[0] | lfsr[2]) : 1'b1;
  end

  // monitor: compares every accepted write against the scoreboard
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (mem_req) req_seen++;
      if (irq) irq_seen++;
      if (mem_req && !cpu_halt) check(0, "R7 halt low during request", {31'b0, cpu_halt}, 32'd1);
      if (mem_req && mem_we && mem_ready) begin
        wr_seen++;
        if (sb.size() == 0) begin
          check(0, "R4 unexpected write", mem_addr, 32'hFFFFFFFF);
        end else begin
          wr_item_t e;
          e = sb.pop_front();
          check(mem_addr == e.addr, "R5 write address", mem_addr, e.addr);
          check(mem_wdata == e.data, "R4 write data", mem_wdata, e.data);
          check(mem_size == e.wide, "R5 unit size", {31'b0, mem_size}, {31'b0, e.wide});
        end
      end
    end
  end

  // driver: restates alignment, stepping and lane rules independently
  task automatic push_copy(input logic [31:0] src, input logic [31:0] dst, input int n, input bit wide);
    int step = wide ? 4 : 2;
    logic [31:0] s = wide ? {src[31:2], 2'b00} : {src[31:1], 1'b0};
    logic [31:0] d = wide ? {dst[31:2], 2'b00} : {dst[31:1], 1'b0};
    for (int i = 0; i < n; i++) begin
      wr_item_t e;
      logic [31:0] v = mem_pattern(s + 32'(i * step));
      e.addr = d + 32'(i * step);
      e.data = wide ? v : {16'h0, v[15:0]};
      e.wide = wide;
      sb.push_back(e);
    end
  endtask

  // called away from an edge; returns 1 ns after the edge that takes it
  task automatic reg_wr(input logic [1:0] sel, input logic [31:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  function automatic logic [31:0] ctl(input bit run, input bit wide, input bit ie, input logic [15:0] n);
    return {run, ie, 3'b000, wide, 10'b0, n};
  endfunction

  task automatic wait_idle();
    do begin @(negedge clk); #2; end while (sb.size() != 0 || cpu_halt);
    @(negedge clk); #2;
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #2; end
  endtask

  int irq0, wr0, req0;

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(mem_req == 0, "R1 mem_req", {31'b0, mem_req}, 0);
    check(cpu_halt == 0, "R1 cpu_halt", {31'b0, cpu_halt}, 0);
    check(irq == 0, "R1 irq", {31'b0, irq}, 0);
    check(ctrl_view == 0, "R1 ctrl_view", ctrl_view, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R2 + R3: latency window, address write at k+1 used, at k+2 not
    reg_wr(2'd0, 32'h0000_1000);
    reg_wr(2'd1, 32'h0000_8000);
    push_copy(32'h0000_2000, 32'h0000_8000, 4, 1);
    irq0 = irq_seen;
    reg_wr(2'd2, ctl(1, 1, 1, 16'd4));                 // edge k
    check(mem_req == 0, "R2 no request after edge k", {31'b0, mem_req}, 0);
    reg_wr(2'd0, 32'h0000_2000);                       // edge k+1
    check(mem_req == 0, "R2 no request after edge k+1", {31'b0, mem_req}, 0);
    reg_wr(2'd0, 32'h0000_3000);                       // edge k+2
    check(mem_req == 1, "R2 request after edge k+2", {31'b0, mem_req}, 1);
    check(mem_addr == 32'h0000_2000, "R3 sampled source", mem_addr, 32'h0000_2000);
    check(cpu_halt == 1, "R7 halt with first request", {31'b0, cpu_halt}, 1);
    wait_idle();
    check(irq_seen - irq0 == 1, "R9 one irq pulse", 32'(irq_seen - irq0), 1);
    check(ctrl_view[31] == 0 && ctrl_view[15:0] == 0, "R8 run and count cleared", ctrl_view, 32'h4400_0000);
    check(ctrl_view[30] && ctrl_view[26], "R8 width and irq bits kept", ctrl_view, 32'h4400_0000);

    // R5 narrow units, misaligned, wait states, no irq
    ready_mode = 1;
    irq0 = irq_seen;
    reg_wr(2'd0, 32'h0000_4003);
    reg_wr(2'd1, 32'h0000_9001);
    push_copy(32'h0000_4003, 32'h0000_9001, 5, 0);
    reg_wr(2'd2, ctl(1, 0, 0, 16'd5));
    wait_idle();
    check(irq_seen == irq0, "R9 no irq when disabled", 32'(irq_seen - irq0), 0);
    check(ctrl_view == 32'h0, "R8 narrow copy done", ctrl_view, 0);

    // R5 wide units, misaligned, wait states
    reg_wr(2'd0, 32'h0000_5006);
    reg_wr(2'd1, 32'h0000_A00B);
    push_copy(32'h0000_5006, 32'h0000_A00B, 3, 1);
    reg_wr(2'd2, ctl(1, 1, 1, 16'd3));
    wait_idle();

    // R11: back-to-back without a disable write
    ready_mode = 0;
    wr0 = wr_seen;
    reg_wr(2'd0, 32'h0000_6000);
    reg_wr(2'd1, 32'h0000_B000);
    push_copy(32'h0000_6000, 32'h0000_B000, 2, 1);
    reg_wr(2'd2, ctl(1, 1, 0, 16'd2));
    check(mem_req == 0, "R11 latency kept after edge k", {31'b0, mem_req}, 0);
    wait_idle();
    check(wr_seen - wr0 == 2, "R11 second copy ran", 32'(wr_seen - wr0), 2);

    // R10: cancel while pending
    req0 = req_seen; wr0 = wr_seen;
    reg_wr(2'd2, ctl(1, 1, 0, 16'd4));
    reg_wr(2'd2, 32'h0);
    idle_cycles(10);
    check(req_seen == req0, "R10 no request after pending cancel", 32'(req_seen - req0), 0);
    check(cpu_halt == 0, "R10 halt low after pending cancel", {31'b0, cpu_halt}, 0);
    check(ctrl_view == 0, "R10 control reads written zero", ctrl_view, 0);

    // R10: cancel while running
    push_copy(32'h0000_6000, 32'h0000_C000, 20, 1);
    reg_wr(2'd0, 32'h0000_6000);
    reg_wr(2'd1, 32'h0000_C000);
    wr0 = wr_seen;
    reg_wr(2'd2, ctl(1, 1, 1, 16'd20));
    while (wr_seen - wr0 < 3) begin @(negedge clk); #2; end
    irq0 = irq_seen;
    reg_wr(2'd2, 32'h0);
    check(mem_req == 0, "R10 request gone after running cancel", {31'b0, mem_req}, 0);
    check(cpu_halt == 0, "R10 halt low after running cancel", {31'b0, cpu_halt}, 0);
    sb.delete();
    wr0 = wr_seen;
    idle_cycles(10);
    check(wr_seen == wr0, "R10 no writes after cancel", 32'(wr_seen - wr0), 0);
    check(irq_seen == irq0, "R10 no irq after cancel", 32'(irq_seen - irq0), 0);

    // R6: count field zero moves 65536 narrow units
    reg_wr(2'd0, 32'h0000_0000);
    reg_wr(2'd1, 32'h0002_0000);
    push_copy(32'h0000_0000, 32'h0002_0000, 65536, 0);
    wr0 = wr_seen;
    reg_wr(2'd2, ctl(1, 0, 0, 16'd0));
    wait_idle();
    check(wr_seen - wr0 == 65536, "R6 zero count means 65536", 32'(wr_seen - wr0), 32'd65536);
    check(ctrl_view[31] == 0, "R8 run cleared after full range", ctrl_view, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  // watchdog
  initial begin
    repeat (198000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule